// File: doc/BRIEF.md
# Privilege and Banked Stack-Pointer Control

This block keeps track of whether the core is running ordinary code (thread mode) or servicing an exception (handler mode), what access level applies, and which of two stack pointers, main or process, is the live one. It holds a two-bit control register and the two banked stack-pointer registers. Exception entry and exception return arrive as one-cycle strobes. Software reaches the control register and the stack pointers through a write port for each, and can read either stack bank through a separate read port.

Dropping privilege is a one-way step for thread code. A write that tries to clear the unprivileged flag from unprivileged thread code is discarded and flagged. Privilege comes back only through an exception: handler code always runs privileged on the main stack and may rewrite the control register before it returns. Any stack-pointer value written is forced to word alignment.

Top module: `privsp_ctrl`

## Requirements
- R1: The reset input is synchronous and active low. Reset clears the control register to 0 and both stack registers to 0. After reset the block is in thread mode, privileged, with the main stack active and `ignored_wr_o` low.
- R2: An `exc_entry_i` pulse puts the block in handler mode on the next edge. An `exc_return_i` pulse puts it back in thread mode. When both pulse in the same cycle, entry wins. A return while already in thread mode changes nothing.
- R3: In handler mode `privileged_o` is 1 and the main stack is active (`use_psp_o` = 0), whatever the control register holds.
- R4: In thread mode `privileged_o` is the inverse of control bit 0. The process stack is active exactly when control bit 1 is 1.
- R5: Control bit 0 = 1 marks thread code unprivileged, and bit 1 = 1 selects the process stack. A control write made in handler mode or in privileged thread mode loads both bits on the next edge.
- R6: A control write made in unprivileged thread mode leaves the register unchanged, and `ignored_wr_o` is high in that same cycle.
- R7: After an exception is entered from unprivileged thread mode, handler code can clear bit 0. The block then returns to thread mode privileged.
- R8: A stack write with select 0 (active) updates only the bank that is active at that moment. This write is allowed at any privilege level.
- R9: Stack write select 1 writes the main bank and select 2 writes the process bank, but only when privileged. From unprivileged thread mode these writes are dropped. Select 3 is always dropped. Every dropped stack write raises `ignored_wr_o` in its cycle.
- R10: Every stored stack value has its two least significant bits forced to 0.
- R11: `sp_rd_data_o` returns the main bank when `sp_rd_sel_i` = 0 and the process bank when it is 1, in any mode, without latency.
- R12: `active_sp_o` always shows the value of the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| ctrl_wr_en_i | input | 1 | Control register write enable |
| ctrl_wr_data_i | input | 2 | Control write data (bit0 unprivileged, bit1 process stack) |
| sp_wr_en_i | input | 1 | Stack pointer write enable |
| sp_wr_sel_i | input | 2 | 0 active, 1 main, 2 process, 3 none |
| sp_wr_data_i | input | SP_W | Stack pointer write data |
| sp_rd_sel_i | input | 1 | Read bank: 0 main, 1 process |
| handler_mode_o | output | 1 | 1 in handler mode |
| privileged_o | output | 1 | Effective privilege |
| ctrl_o | output | 2 | Control register contents |
| use_psp_o | output | 1 | 1 when the process stack is active |
| active_sp_o | output | SP_W | Value of the active stack pointer |
| sp_rd_data_o | output | SP_W | Selected bank read data |
| ignored_wr_o | output | 1 | A write in this cycle is being dropped |

## Verification
A stimulus table walks the block through five phases in order: privileged thread, unprivileged thread, handler mode, a return, and a collision of entry with return. Each stack write is made once through the active select and once through an explicit bank select. Putting the same write pattern in different modes separates three things: a write that goes to the wrong bank, a privilege check that ignores handler mode, and an escalation guard that is missing. Unaligned write data and a read of both banks at the end show the forced alignment and the read selection. A reset applied in mid-run then confirms the initial state.

// File: rtl/privsp_pkg.sv
// Shared types for the privilege and stack-pointer control block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package privsp_pkg;
    typedef enum logic [1:0] {
        SPW_ACTIVE = 2'd0,
        SPW_MAIN   = 2'd1,
        SPW_PROC   = 2'd2,
        SPW_NONE   = 2'd3
    } spw_sel_e;

    localparam int CTRL_W      = 2;
    localparam int CTRL_UNPRIV = 0;
    localparam int CTRL_PSP    = 1;
    localparam int NUM_BANKS   = 2;
endpackage

// File: rtl/privsp_mode.sv
// Execution mode tracker: one flag, set by exception entry, cleared by return.
// Assumes entry/return are single-cycle strobes; nesting depth is handled elsewhere.
module privsp_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_i,
    input  logic return_i,
    output logic handler_o
);
    logic handler_q;

    // Mode register: entry has priority over return in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        handler_q <= 1'b0;
        else if (entry_i)  handler_q <= 1'b1;
        else if (return_i) handler_q <= 1'b0;
    end

    assign handler_o = handler_q;

    a_r2_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> handler_q);
    a_r2_return_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (return_i && !entry_i) |=> !handler_q);
endmodule

// File: rtl/privsp_ctrl_reg.sv
// Two-bit control register with the no-escalation rule.
// Assumes handler_i reflects the current mode register (same cycle).
module privsp_ctrl_reg
    import privsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              blocked_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              unpriv_thread;

    // Unprivileged thread code may not touch the register at all.
    always_comb unpriv_thread = !handler_i && ctrl_q[CTRL_UNPRIV];
    always_comb blocked_o     = wr_en_i && unpriv_thread;

    // Register update: accept only writes made with privilege.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctrl_q <= '0;
        else if (wr_en_i && !blocked_o) ctrl_q <= wr_data_i;
    end

    assign ctrl_o = ctrl_q;

    a_r6_no_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !handler_i && ctrl_q[CTRL_UNPRIV]) |=> $stable(ctrl_q));
    a_r5_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (handler_i || !ctrl_q[CTRL_UNPRIV])) |=> (ctrl_q == $past(wr_data_i)));
endmodule

// File: rtl/privsp_sp_bank.sv
// Banked main/process stack-pointer registers with aligned writes,
// active-bank and explicit-bank write selection and a bank read port.
// Assumes psp_sel_i is already forced low in handler mode by the parent.
module privsp_sp_bank
    import privsp_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unpriv_i,
    input  logic            psp_sel_i,
    input  logic            wr_en_i,
    input  spw_sel_e        wr_sel_i,
    input  logic [SP_W-1:0] wr_data_i,
    input  logic            rd_sel_i,
    output logic [SP_W-1:0] rd_data_o,
    output logic [SP_W-1:0] active_o,
    output logic            blocked_o
);
    localparam logic [SP_W-1:0] KEEP_MASK = {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    logic [SP_W-1:0] bank_q [NUM_BANKS];
    logic [SP_W-1:0] wr_aligned;

    // Word alignment of every written value.
    always_comb wr_aligned = wr_data_i & KEEP_MASK;

    // Dropped writes: reserved select, or explicit bank access without privilege.
    always_comb blocked_o = wr_en_i &&
        ((wr_sel_i == SPW_NONE) ||
         (unpriv_i && (wr_sel_i == SPW_MAIN || wr_sel_i == SPW_PROC)));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam spw_sel_e EXPL = (g == 0) ? SPW_MAIN : SPW_PROC;
        logic hit;

        // Bank g is written via the active select or its own explicit select.
        always_comb hit = wr_en_i &&
            ((wr_sel_i == SPW_ACTIVE && (int'(psp_sel_i) == g)) ||
             (!unpriv_i && wr_sel_i == EXPL));

        // Bank register storage.
        always_ff @(posedge clk) begin
            if (!rst_n)   bank_q[g] <= '0;
            else if (hit) bank_q[g] <= wr_aligned;
        end

        a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (bank_q[g][ALIGN_BITS-1:0] == '0));
        a_r8_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_sel_i == SPW_ACTIVE && int'(psp_sel_i) == g)
            |=> $stable(bank_q[NUM_BANKS-1-g]));
    end

    assign active_o  = bank_q[psp_sel_i];
    assign rd_data_o = bank_q[rd_sel_i];
endmodule

// File: rtl/privsp_ctrl.sv
// Top: execution mode, effective privilege and banked stack pointer control.
// Assumes exception strobes are one cycle wide and writes are sampled each edge.
module privsp_ctrl
    import privsp_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_entry_i,
    input  logic            exc_return_i,
    input  logic            ctrl_wr_en_i,
    input  logic [1:0]      ctrl_wr_data_i,
    input  logic            sp_wr_en_i,
    input  logic [1:0]      sp_wr_sel_i,
    input  logic [SP_W-1:0] sp_wr_data_i,
    input  logic            sp_rd_sel_i,
    output logic            handler_mode_o,
    output logic            privileged_o,
    output logic [1:0]      ctrl_o,
    output logic            use_psp_o,
    output logic [SP_W-1:0] active_sp_o,
    output logic [SP_W-1:0] sp_rd_data_o,
    output logic            ignored_wr_o
);
    logic              handler;
    logic [CTRL_W-1:0] ctrl;
    logic              unpriv_thread;
    logic              psp_sel;
    logic              ctrl_blocked;
    logic              sp_blocked;

    privsp_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .entry_i   (exc_entry_i),
        .return_i  (exc_return_i),
        .handler_o (handler)
    );

    privsp_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .handler_i (handler),
        .wr_en_i   (ctrl_wr_en_i),
        .wr_data_i (ctrl_wr_data_i),
        .ctrl_o    (ctrl),
        .blocked_o (ctrl_blocked)
    );

    // Effective privilege and stack selection: handler forces privileged + main.
    always_comb begin
        unpriv_thread = !handler && ctrl[CTRL_UNPRIV];
        psp_sel       = !handler && ctrl[CTRL_PSP];
    end

    privsp_sp_bank #(.SP_W(SP_W), .ALIGN_BITS(ALIGN_BITS)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .unpriv_i  (unpriv_thread),
        .psp_sel_i (psp_sel),
        .wr_en_i   (sp_wr_en_i),
        .wr_sel_i  (spw_sel_e'(sp_wr_sel_i)),
        .wr_data_i (sp_wr_data_i),
        .rd_sel_i  (sp_rd_sel_i),
        .rd_data_o (sp_rd_data_o),
        .active_o  (active_sp_o),
        .blocked_o (sp_blocked)
    );

    assign handler_mode_o = handler;
    assign privileged_o   = !unpriv_thread;
    assign ctrl_o         = ctrl;
    assign use_psp_o      = psp_sel;
    assign ignored_wr_o   = ctrl_blocked || sp_blocked;

    a_r3_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry_i |=> (privileged_o && !use_psp_o));
    a_r12_active_value: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en_i && sp_wr_sel_i == 2'd0) |=> (active_sp_o == ($past(sp_wr_data_i) & {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}}))
        || $past(exc_entry_i) || $past(exc_return_i) || $past(ctrl_wr_en_i));
endmodule

// File: tb/privsp_ctrl_tb_top.sv
module privsp_ctrl_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ent = 1'b0, ret = 1'b0, cwe = 1'b0, swe = 1'b0, rsel = 1'b0;
    logic [1:0]   cwd = '0, ssel = '0;
    logic [W-1:0] sd = '0;
    logic         hand, priv, upsp, ign;
    logic [1:0]   ctrl;
    logic [W-1:0] act, rdat;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    privsp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_entry_i(ent), .exc_return_i(ret),
        .ctrl_wr_en_i(cwe), .ctrl_wr_data_i(cwd), .sp_wr_en_i(swe),
        .sp_wr_sel_i(ssel), .sp_wr_data_i(sd), .sp_rd_sel_i(rsel),
        .handler_mode_o(hand), .privileged_o(priv), .ctrl_o(ctrl),
        .use_psp_o(upsp), .active_sp_o(act), .sp_rd_data_o(rdat),
        .ignored_wr_o(ign)
    );

    typedef struct packed {
        logic       ent, ret, cwe;
        logic [1:0] cwd;
        logic       swe;
        logic [1:0] ssel;
        logic [31:0] sd;
        logic       eflag, ehand, epriv;
        logic [1:0] ectrl;
        logic [31:0] eact;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R8 R10: active write in privileged thread goes to main
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,32'h0000_1003, 1'b0,1'b0,1'b1,2'd0,32'h0000_1000},
        // R9: explicit process write when privileged
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd2,32'h0000_2007, 1'b0,1'b0,1'b1,2'd0,32'h0000_1000},
        // R4 R5 R12: select process stack
        '{1'b0,1'b0,1'b1,2'd2,1'b0,2'd0,32'h0,         1'b0,1'b0,1'b1,2'd2,32'h0000_2004},
        // R8: active write now hits process
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,32'h0000_2100, 1'b0,1'b0,1'b1,2'd2,32'h0000_2100},
        // R4 R5: drop privilege
        '{1'b0,1'b0,1'b1,2'd3,1'b0,2'd0,32'h0,         1'b0,1'b0,1'b0,2'd3,32'h0000_2100},
        // R6: escalation attempt dropped
        '{1'b0,1'b0,1'b1,2'd0,1'b0,2'd0,32'h0,         1'b1,1'b0,1'b0,2'd3,32'h0000_2100},
        // R9: explicit main write unprivileged dropped
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd1,32'h0000_5000, 1'b1,1'b0,1'b0,2'd3,32'h0000_2100},
        // R2 R3: exception entry -> handler, privileged, main stack
        '{1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,32'h0,         1'b0,1'b1,1'b1,2'd3,32'h0000_1000},
        // R8 R10: active write in handler hits main, aligned
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,32'h0000_1FF3, 1'b0,1'b1,1'b1,2'd3,32'h0000_1FF0},
        // R7: handler clears unprivileged bit
        '{1'b0,1'b0,1'b1,2'd2,1'b0,2'd0,32'h0,         1'b0,1'b1,1'b1,2'd2,32'h0000_1FF0},
        // R2 R7: return to privileged thread on process stack
        '{1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,32'h0,         1'b0,1'b0,1'b1,2'd2,32'h0000_2100},
        // R2: entry and return together -> entry wins
        '{1'b1,1'b1,1'b0,2'd0,1'b0,2'd0,32'h0,         1'b0,1'b1,1'b1,2'd2,32'h0000_1FF0},
        // R2: return
        '{1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,32'h0,         1'b0,1'b0,1'b1,2'd2,32'h0000_2100},
        // R2: return in thread has no effect
        '{1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,32'h0,         1'b0,1'b0,1'b1,2'd2,32'h0000_2100},
        // R9: select 3 always dropped
        '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd3,32'h0000_1234, 1'b1,1'b0,1'b1,2'd2,32'h0000_2100}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_reset_state();
        chk("R1 handler", {31'b0, hand}, 32'd0);
        chk("R1 priv",    {31'b0, priv}, 32'd1);
        chk("R1 ctrl",    {30'b0, ctrl}, 32'd0);
        chk("R1 psp",     {31'b0, upsp}, 32'd0);
        chk("R1 active",  act, 32'd0);
        chk("R1 flag",    {31'b0, ign}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            ent = VECS[i].ent; ret = VECS[i].ret; cwe = VECS[i].cwe; cwd = VECS[i].cwd;
            swe = VECS[i].swe; ssel = VECS[i].ssel; sd = VECS[i].sd;
            #2;
            chk("R6 flag", {31'b0, ign}, {31'b0, VECS[i].eflag});
            @(negedge clk);
            chk("R2 mode", {31'b0, hand}, {31'b0, VECS[i].ehand});
            chk("R3 priv", {31'b0, priv}, {31'b0, VECS[i].epriv});
            chk("R5 ctrl", {30'b0, ctrl}, {30'b0, VECS[i].ectrl});
            chk("R12 active", act, VECS[i].eact);
        end
        ent = 0; ret = 0; cwe = 0; swe = 0; ssel = 0; sd = '0;
        // R11: both banks readable
        rsel = 1'b0; #2;
        chk("R11 main read", rdat, 32'h0000_1FF0);
        rsel = 1'b1; #2;
        chk("R11 proc read", rdat, 32'h0000_2100);
        // R4: thread on process stack reports use_psp
        chk("R4 use_psp", {31'b0, upsp}, 32'd1);
        // R10: explicit write with unaligned data
        @(negedge clk);
        swe = 1'b1; ssel = 2'd1; sd = 32'hFFFF_FFFF;
        @(negedge clk);
        swe = 1'b0; rsel = 1'b0; #2;
        chk("R10 align", rdat, 32'hFFFF_FFFC);
        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rsel = 1'b1; #2;
        chk("R1 proc cleared", rdat, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule